// File: doc/BRIEF.md
# Open-page DDR command sequencer

This block converts host read and write requests into DDR SDRAM command sequences. It keeps a row open in each of four banks between accesses. It precharges a bank only when a later request to that bank needs a different row. Every column command moves a fixed burst of four data beats.

The host presents one request at a time on a valid/ready port. A request carries a linear address, a write flag and a byte mask for each beat. The memory side is a registered command bus: chip select, row strobe, column strobe, write enable, bank and a multiplexed address. A beat counter follows each column command and strobes data capture.

Two programmable gaps are enforced between commands:
- the precharge-to-activate gap;
- the activate-to-column gap.

Top module: `ddr_seq`

## Requirements
- R1: After reset the request port is ready, chip select is high, the command lines are 111 and no beat is strobed. The open-row table starts with every bank closed.
- R2: Command encodings on {ras_n, cas_n, we_n} with chip select low are: activate 011, read 101, write 100, precharge 010. In every other cycle chip select is high and the lines are 111.
- R3: The linear address is split from the MSB down as {row[12:0], bank[1:0], column[COL_W-1:0]}, with COL_W of 10 by default (9 allowed). Activate drives the row on the address bus. Read and write drive the zero-extended column. Precharge drives address 0.
- R4: A request to a closed bank issues activate and then the column command, with no precharge.
- R5: A request to the row already open in its bank issues only the column command. It appears in the cycle after the accepting clock edge.
- R6: A request to a different row in an open bank issues precharge, then activate, then the column command, all to that bank.
- R7: Activate follows precharge exactly trp_i cycles later (trp_i from 1 to 15).
- R8: The column command follows activate exactly trcd_i cycles later (trcd_i from 1 to 15).
- R9: The four cycles after a column command strobe beats with indices 0, 1, 2, 3. beat_we_o is high for a write.
- R10: During a write burst, beat k drives mask bits [4k+3:4k], where a 1 means the byte is masked. During a read burst the beat mask is 0 whatever mask was presented.
- R11: The port drops ready after accepting a request. It raises ready again in the cycle that carries beat 3, and issues no command during a burst.
- R12: Banks are tracked independently, so opening a row in one bank does not change the hit or miss outcome in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trp_i | input | GAP_W | Precharge-to-activate gap in cycles |
| trcd_i | input | GAP_W | Activate-to-column gap in cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ROW_W+BANK_W+COL_W | Linear address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_mask_i | input | BEATS*BYTES | Per-beat byte mask, 1 = masked |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ROW_W | Multiplexed row/column address |
| beat_valid_o | output | 1 | Data beat strobe |
| beat_idx_o | output | log2(BEATS) | Beat index within burst |
| beat_we_o | output | 1 | Beat belongs to a write burst |
| beat_mask_o | output | BYTES | Byte mask of the current beat |

## Verification
Take the acceptance edge as the clock edge at which valid and ready are both high. The first command of a request shows on the bus one cycle after that edge. Activate follows precharge by exactly trp_i cycles, and the column command follows activate by exactly trcd_i cycles. Beats 0 to 3 occupy the four cycles after the column command, and ready returns in the cycle of beat 3.

A monitor samples the bus on the falling clock edge and time-stamps every command and beat with the count of rising edges. The directed tasks compare each stamp with the cycle derived from these rules, using a per-bank row model kept in the bench.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_BURST
  } st_e;
endpackage

// File: rtl/ddr_addr_split.sv
module ddr_addr_split #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  assign col_o  = addr_i[COL_W-1:0];
  assign bank_o = addr_i[COL_W +: BANK_W];
  assign row_o  = addr_i[COL_W+BANK_W +: ROW_W];
endmodule

// File: rtl/ddr_row_table.sv
module ddr_row_table #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  localparam int NB = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic              rd_open_o,
  output logic [ROW_W-1:0]  rd_row_o
);
  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (wr_bank_i == BANK_W'(b)) begin
        if (open_i) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= wr_row_i;
        end else if (close_i) begin
          open_q[b] <= 1'b0;
        end
      end
    end
  end

  assign rd_open_o = open_q[rd_bank_i];
  assign rd_row_o  = row_q[rd_bank_i];
endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  output logic             done_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // next command may issue on the edge where the loaded gap has elapsed
  assign done_o = (cnt_q <= GAP_W'(1));
endmodule

// File: rtl/ddr_seq.sv
module ddr_seq
  import ddr_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int BEATS  = 4,
  parameter int BYTES  = 4,
  parameter int GAP_W  = 4,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int MASK_W = BEATS * BYTES,
  localparam int BC_W   = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAP_W-1:0]  trp_i,
  input  logic [GAP_W-1:0]  trcd_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [MASK_W-1:0] req_mask_i,
  output logic              cmd_cs_n_o,
  output logic              cmd_ras_n_o,
  output logic              cmd_cas_n_o,
  output logic              cmd_we_n_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_addr_o,
  output logic              beat_valid_o,
  output logic [BC_W-1:0]   beat_idx_o,
  output logic              beat_we_o,
  output logic [BYTES-1:0]  beat_mask_o
);
  logic [ROW_W-1:0]  a_row;
  logic [BANK_W-1:0] a_bank;
  logic [COL_W-1:0]  a_col;
  logic              tb_open;
  logic [ROW_W-1:0]  tb_row;
  logic              gap_done;

  st_e               st_q;
  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [MASK_W-1:0] mask_q;
  logic [BC_W-1:0]   bcnt_q;

  logic accept, hit, issue_pre, issue_act, issue_col;

  ddr_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
    .addr_i(req_addr_i), .row_o(a_row), .bank_o(a_bank), .col_o(a_col)
  );

  ddr_row_table #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_table (
    .clk_i, .rst_ni,
    .open_i(issue_act), .close_i(issue_pre),
    .wr_bank_i(bank_q), .wr_row_i(row_q),
    .rd_bank_i(a_bank), .rd_open_o(tb_open), .rd_row_o(tb_row)
  );

  ddr_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i, .rst_ni,
    .load_i(issue_pre | issue_act),
    .val_i(issue_pre ? trp_i : trcd_i),
    .done_o(gap_done)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;
  assign hit         = tb_open && (tb_row == a_row);
  assign issue_pre   = (st_q == ST_PRE) && gap_done;
  assign issue_act   = (st_q == ST_ACT) && gap_done;
  assign issue_col   = (st_q == ST_COL) && gap_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      row_q        <= '0;
      bank_q       <= '0;
      col_q        <= '0;
      we_q         <= 1'b0;
      mask_q       <= '0;
      bcnt_q       <= '0;
      cmd_cs_n_o   <= 1'b1;
      {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} <= CMD_NOP;
      cmd_bank_o   <= '0;
      cmd_addr_o   <= '0;
      beat_valid_o <= 1'b0;
      beat_idx_o   <= '0;
      beat_we_o    <= 1'b0;
      beat_mask_o  <= '0;
    end else begin
      cmd_cs_n_o   <= 1'b1;
      {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} <= CMD_NOP;
      beat_valid_o <= 1'b0;
      beat_we_o    <= 1'b0;
      beat_mask_o  <= '0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          row_q  <= a_row;
          bank_q <= a_bank;
          col_q  <= a_col;
          we_q   <= req_we_i;
          mask_q <= req_mask_i;
          st_q   <= hit ? ST_COL : (tb_open ? ST_PRE : ST_ACT);
        end
        ST_PRE: if (issue_pre) begin
          cmd_cs_n_o <= 1'b0;
          {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} <= CMD_PRE;
          cmd_bank_o <= bank_q;
          cmd_addr_o <= '0;
          st_q       <= ST_ACT;
        end
        ST_ACT: if (issue_act) begin
          cmd_cs_n_o <= 1'b0;
          {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} <= CMD_ACT;
          cmd_bank_o <= bank_q;
          cmd_addr_o <= row_q;
          st_q       <= ST_COL;
        end
        ST_COL: if (issue_col) begin
          cmd_cs_n_o <= 1'b0;
          {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o} <= we_q ? CMD_WR : CMD_RD;
          cmd_bank_o <= bank_q;
          cmd_addr_o <= ROW_W'(col_q);
          bcnt_q     <= '0;
          st_q       <= ST_BURST;
        end
        ST_BURST: begin
          beat_valid_o <= 1'b1;
          beat_idx_o   <= bcnt_q;
          beat_we_o    <= we_q;
          beat_mask_o  <= we_q ? mask_q[bcnt_q*BYTES +: BYTES] : '0;
          bcnt_q       <= bcnt_q + 1'b1;
          if (bcnt_q == BC_W'(BEATS-1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module ddr_seq_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int BYTES  = 4,
  parameter int BC_W   = 2,
  parameter int GAP_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [GAP_W-1:0]  trp_i,
  input logic [GAP_W-1:0]  trcd_i,
  input logic              req_ready_o,
  input logic              cmd_cs_n_o,
  input logic              cmd_ras_n_o,
  input logic              cmd_cas_n_o,
  input logic              cmd_we_n_o,
  input logic              beat_valid_o,
  input logic [BC_W-1:0]   beat_idx_o,
  input logic              beat_we_o,
  input logic [BYTES-1:0]  beat_mask_o
);
  localparam int CW = GAP_W + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0] enc;
  logic is_pre, is_act, is_col;
  logic [CW-1:0] since_pre, since_act;

  assign enc    = {cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o};
  assign is_pre = !cmd_cs_n_o && enc == 3'b010;
  assign is_act = !cmd_cs_n_o && enc == 3'b011;
  assign is_col = !cmd_cs_n_o && (enc == 3'b101 || enc == 3'b100);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre <= CMAX;
      since_act <= CMAX;
    end else begin
      if (is_pre) since_pre <= CW'(1);
      else if (since_pre != CMAX) since_pre <= since_pre + 1'b1;
      if (is_act) since_act <= CW'(1);
      else if (since_act != CMAX) since_act <= since_act + 1'b1;
    end
  end

  p_cmd_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_cs_n_o |-> (is_pre || is_act || is_col));
  p_desel_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_cs_n_o |-> enc == 3'b111);
  p_trp_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_pre >= CW'(trp_i));
  p_trcd_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> since_act >= CW'(trcd_i));
  p_col_beat0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |=> beat_valid_o && beat_idx_o == '0);
  p_beat_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_idx_o != '1) |=>
      (beat_valid_o && beat_idx_o == $past(beat_idx_o) + 1'b1));
  p_read_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_we_o) |-> beat_mask_o == '0);
  p_busy_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_idx_o != '1) |-> !req_ready_o);
  p_quiet_burst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> cmd_cs_n_o);
endmodule

bind ddr_seq ddr_seq_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .BYTES(BYTES), .BC_W(BC_W), .GAP_W(GAP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trp_i(trp_i), .trcd_i(trcd_i),
  .req_ready_o(req_ready_o), .cmd_cs_n_o(cmd_cs_n_o),
  .cmd_ras_n_o(cmd_ras_n_o), .cmd_cas_n_o(cmd_cas_n_o), .cmd_we_n_o(cmd_we_n_o),
  .beat_valid_o(beat_valid_o), .beat_idx_o(beat_idx_o),
  .beat_we_o(beat_we_o), .beat_mask_o(beat_mask_o)
);

// File: tb/ddr_seq_tb.sv
`timescale 1ns/1ps
module ddr_seq_tb_top;
  localparam int ROW_W = 13, BANK_W = 2, COL_W = 10, BEATS = 4, BYTES = 4, GAP_W = 4;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int MASK_W = BEATS * BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [GAP_W-1:0] trp = 4'd2, trcd = 4'd3;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [MASK_W-1:0] req_mask = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, beat_valid, beat_we;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;
  logic [1:0] beat_idx;
  logic [BYTES-1:0] beat_mask;

  always #10 clk = ~clk;

  ddr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trp_i(trp), .trcd_i(trcd),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_mask_i(req_mask),
    .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .beat_valid_o(beat_valid), .beat_idx_o(beat_idx), .beat_we_o(beat_we),
    .beat_mask_o(beat_mask)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor log
  int cn = 0, bn = 0, rdy_cyc = -1;
  logic rdy_prev = 1'b1;
  logic [2:0] l_enc [8];
  logic [1:0] l_bank [8];
  logic [12:0] l_addr [8];
  int l_t [8];
  logic [1:0] b_idx [8];
  logic b_we [8];
  logic [3:0] b_mask [8];
  int b_t [8];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (cn < 8) begin
          l_enc[cn] = {ras_n, cas_n, we_n}; l_bank[cn] = cmd_bank;
          l_addr[cn] = cmd_addr; l_t[cn] = cyc;
        end
        cn++;
      end
      if (beat_valid) begin
        if (bn < 8) begin
          b_idx[bn] = beat_idx; b_we[bn] = beat_we; b_mask[bn] = beat_mask; b_t[bn] = cyc;
        end
        bn++;
      end
      if (req_ready && !rdy_prev && rdy_cyc < 0) rdy_cyc = cyc;
      rdy_prev = req_ready;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference per-bank row model
  bit m_open [4];
  logic [12:0] m_row [4];

  task automatic run(input logic [12:0] row, input logic [1:0] bank, input logic [9:0] col,
                     input logic we, input logic [15:0] mask, input string req);
    int acc, t0, n, ct;
    logic [2:0] e_enc [3];
    logic [12:0] e_addr [3];
    int e_t [3];
    @(posedge clk);
    cn = 0; bn = 0; rdy_cyc = -1;
    @(negedge clk);
    req_addr = {row, bank, col}; req_we = we; req_mask = mask; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 200 && rdy_cyc < 0; g++) @(negedge clk);
    repeat (2) @(negedge clk);
    t0 = acc + 2;
    n = 0;
    if (m_open[bank] && m_row[bank] != row) begin
      e_enc[n] = 3'b010; e_addr[n] = '0; e_t[n] = t0; n++;
      t0 += int'(trp);
    end
    if (!(m_open[bank] && m_row[bank] == row)) begin
      e_enc[n] = 3'b011; e_addr[n] = row; e_t[n] = t0; n++;
      t0 += int'(trcd);
    end
    e_enc[n] = we ? 3'b100 : 3'b101; e_addr[n] = {3'b000, col}; e_t[n] = t0; n++;
    ct = t0;
    chk(cn == n, req, "command count", cn, n);
    for (int i = 0; i < n && i < cn; i++) begin
      chk(l_enc[i] == e_enc[i], "R2", "command encoding", l_enc[i], e_enc[i]);
      chk(l_bank[i] == bank, req, "command bank", l_bank[i], bank);
      chk(l_addr[i] == e_addr[i], "R3", "command address", l_addr[i], e_addr[i]);
      chk(l_t[i] == e_t[i], req, "command cycle", l_t[i], e_t[i]);
    end
    chk(bn == 4, "R9", "beat count", bn, 4);
    for (int k = 0; k < 4 && k < bn; k++) begin
      chk(b_t[k] == ct + 1 + k && b_idx[k] == 2'(k) && b_we[k] == we, "R9",
          "beat cycle/idx/we", {b_t[k], 8'(b_idx[k]), 4'(b_we[k])},
          {ct + 1 + k, 8'(k), 4'(we)});
      chk(b_mask[k] == (we ? mask[4*k +: 4] : 4'h0), "R10", "beat mask",
          b_mask[k], we ? mask[4*k +: 4] : 4'h0);
    end
    chk(rdy_cyc == ct + 4, "R11", "ready return cycle", rdy_cyc, ct + 4);
    m_open[bank] = 1'b1; m_row[bank] = row;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && cs_n && !beat_valid && {ras_n, cas_n, we_n} == 3'b111, "R1",
        "reset state", {req_ready, cs_n, beat_valid, ras_n, cas_n, we_n}, 6'b110111);
  endtask

  task automatic t_closed_read;  // R4, R8: first access to a closed bank
    trp = 4'd2; trcd = 4'd3;
    run(13'd5, 2'd0, 10'h012, 1'b0, 16'hFFFF, "R4");
  endtask

  task automatic t_hit_write;  // R5, R10: open row, masks per beat
    run(13'd5, 2'd0, 10'h3FF, 1'b1, 16'h8421, "R5");
  endtask

  task automatic t_miss_read;  // R6, R7
    trp = 4'd5; trcd = 4'd1;
    run(13'h1ABC, 2'd0, 10'h155, 1'b0, 16'h0000, "R6");
  endtask

  task automatic t_other_bank;  // R12: bank 2 closed despite bank 0 open with the same row
    trp = 4'd1; trcd = 4'd2;
    run(13'h1ABC, 2'd2, 10'h001, 1'b1, 16'h0F0F, "R12");
    run(13'h1ABC, 2'd0, 10'h200, 1'b1, 16'hA5C3, "R12");
  endtask

  task automatic t_max_gaps;  // R7, R8 at upper limit
    trp = 4'd15; trcd = 4'd15;
    run(13'h0001, 2'd2, 10'h0AA, 1'b0, 16'h1234, "R7");
    run(13'h1FFF, 2'd3, 10'h3FE, 1'b1, 16'hFFFF, "R8");
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed_read();
    t_hit_write();
    t_miss_read();
    t_other_bank();
    t_max_gaps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule